// File: doc/BRIEF.md
# Burst-Mode ADC Sequencer

This block runs a burst of analog-to-digital conversions with no processor in the loop. A start event, taken from one of several timer or pin sources picked by a select field, wakes the converter and waits a programmable settling time. It then performs a programmed number of track-and-convert rounds, adding every result into a 16-bit sum. When the burst is complete the sum is presented with a one-cycle completion pulse, and the converter is returned to low-power shutdown.

The analog converter sits outside the block. It is reached through a start pulse, a done strobe and a result bus. Software or a system controller sets the select fields and timing counts, then reads the sum when the completion pulse appears. Averaging is a right shift by the log2 of the sample count and is left to the consumer.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset, busy, cnv_en, cnv_start and burst_done are low and acc_out is zero.
- R2: src_sel picks the start source: 0 = sw_start, 1 = tmr0_ovf, 2 = tmr2_ovf, 3 = tmr3_ovf, 4 = ext_cnv_pin. Codes 5 to 7 select no source. A source that is not selected never starts a burst.
- R3: ext_cnv_pin passes through two synchronising flops and is acted on only at its rising edge. With the pin first sampled high at rising clock edge 1, busy is high after edge 3. A pin that is held high starts only one burst.
- R4: With settle_cnt = S and track_cnt = T, the first cnv_start of a burst is high in the cycle after rising edge S+T+2, where edge 1 is the edge that accepts the trigger.
- R5: rpt_sel sets the number of conversions in a burst: 0 → 1, 1 → 4, 2 → 8, 3 → 16, 4 → 32, and 5 to 7 → 1. Each burst issues exactly that many cnv_start pulses, each of which is answered by one cnv_done.
- R6: acc_out at burst_done is the sum of all results taken during that burst. The sum is cleared when a burst starts, so earlier bursts do not contribute. 32 full-scale 10-bit results give 32736.
- R7: With a count of 1, acc_out at burst_done equals the single conversion result.
- R8: burst_done is a one-cycle pulse and arrives in the same cycle as the final acc_out. In that cycle cnv_en and busy are still high, and both are low in the following cycle.
- R9: busy and cnv_en stay high from the edge that accepts a trigger through the burst_done cycle. Triggers that arrive while busy is high have no effect, and no burst follows once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Start source select |
| sw_start | input | 1 | Software start request |
| tmr0_ovf | input | 1 | Timer 0 overflow strobe |
| tmr2_ovf | input | 1 | Timer 2 overflow strobe |
| tmr3_ovf | input | 1 | Timer 3 overflow strobe |
| ext_cnv_pin | input | 1 | Asynchronous external convert-start pin |
| rpt_sel | input | 3 | Conversions-per-burst code |
| settle_cnt | input | CNT_W | Power-up settling wait, in cycles minus one |
| track_cnt | input | CNT_W | Track wait before each conversion, in cycles minus one |
| cnv_done | input | 1 | Converter result-valid strobe |
| cnv_result | input | RES_W | Converter result |
| cnv_en | output | 1 | Converter power enable |
| cnv_start | output | 1 | Start-of-conversion pulse |
| busy | output | 1 | Burst in progress |
| acc_out | output | ACC_W | Accumulated sum |
| burst_done | output | 1 | Burst completion pulse |

## Verification
A wrong state or a miscounted wait moves the first cnv_start away from edge S+T+2, and that shows within a few tens of cycles of the trigger. A sample counter that is off by one changes the number of start pulses and the final sum, and this is seen at the first burst_done. A sum that is not cleared, or an add that is skipped, corrupts acc_out for the next burst of several samples. A broken busy guard shows up as an extra burst in the quiet window after burst_done.

// File: rtl/adc_burst_pkg.sv
`timescale 1ns/1ps
package adc_burst_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_POWERUP, S_TRACK, S_CONVERT, S_ACCUM, S_SHUTDOWN
  } seq_state_e;

  localparam logic [2:0] SRC_SW  = 3'd0;
  localparam logic [2:0] SRC_T0  = 3'd1;
  localparam logic [2:0] SRC_T2  = 3'd2;
  localparam logic [2:0] SRC_T3  = 3'd3;
  localparam logic [2:0] SRC_PIN = 3'd4;

  localparam int SMP_W = 6;

  function automatic logic [SMP_W-1:0] rpt_decode(input logic [2:0] code);
    case (code)
      3'd1:    return SMP_W'(4);
      3'd2:    return SMP_W'(8);
      3'd3:    return SMP_W'(16);
      3'd4:    return SMP_W'(32);
      default: return SMP_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/burst_trig_sel.sv
`timescale 1ns/1ps
module burst_trig_sel
  import adc_burst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src_sel,
  input  logic       sw_start,
  input  logic       tmr0_ovf,
  input  logic       tmr2_ovf,
  input  logic       tmr3_ovf,
  input  logic       ext_pin,
  output logic       trig
);
  logic [SYNC_STAGES:0] pin_chain_q;
  logic                 pin_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_chain_q <= '0;
    else        pin_chain_q <= {pin_chain_q[SYNC_STAGES-1:0], ext_pin};
  end

  assign pin_rise = pin_chain_q[SYNC_STAGES-1] & ~pin_chain_q[SYNC_STAGES];

  always_comb begin
    case (src_sel)
      SRC_SW:  trig = sw_start;
      SRC_T0:  trig = tmr0_ovf;
      SRC_T2:  trig = tmr2_ovf;
      SRC_T3:  trig = tmr3_ovf;
      SRC_PIN: trig = pin_rise;
      default: trig = 1'b0;
    endcase
  end

  // R3
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
endmodule

// File: rtl/burst_fsm.sv
`timescale 1ns/1ps
module burst_fsm
  import adc_burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [2:0]       rpt_sel,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic [CNT_W-1:0] track_cnt,
  input  logic             cnv_done,
  output logic             cnv_en,
  output logic             cnv_start,
  output logic             busy,
  output logic             burst_done,
  output logic             acc_clr,
  output logic             acc_add
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, cnt_inc;
  logic [SMP_W-1:0] smp_q, nsamp_q;
  logic             smp_inc, accept;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    smp_inc = 1'b0;
    accept  = 1'b0;
    acc_add = 1'b0;
    case (state_q)
      S_IDLE: if (trig) begin
        accept  = 1'b1;
        cnt_clr = 1'b1;
        state_d = S_POWERUP;
      end
      S_POWERUP: begin
        if (cnt_q == settle_cnt) begin cnt_clr = 1'b1; state_d = S_TRACK; end
        else cnt_inc = 1'b1;
      end
      S_TRACK: begin
        if (cnt_q == track_cnt) begin cnt_clr = 1'b1; state_d = S_CONVERT; end
        else cnt_inc = 1'b1;
      end
      S_CONVERT: if (cnv_done) begin
        acc_add = 1'b1;
        state_d = S_ACCUM;
      end
      S_ACCUM: begin
        if (smp_q == nsamp_q - 1'b1) state_d = S_SHUTDOWN;
        else begin smp_inc = 1'b1; state_d = S_TRACK; end
      end
      S_SHUTDOWN: state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      smp_q   <= '0;
      nsamp_q <= SMP_W'(1);
    end else begin
      state_q <= state_d;
      if (cnt_clr)      cnt_q <= '0;
      else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
      if (accept) begin
        smp_q   <= '0;
        nsamp_q <= rpt_decode(rpt_sel);
      end else if (smp_inc) begin
        smp_q <= smp_q + 1'b1;
      end
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign cnv_en     = busy;
  assign burst_done = (state_q == S_SHUTDOWN);
  assign cnv_start  = (state_q == S_TRACK) && (cnt_q == track_cnt);
  assign acc_clr    = accept;

  // R8
  done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> (!cnv_en && !busy && !burst_done));
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && trig) |=> (state_q == S_POWERUP && smp_q == '0));
  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_done) |=> busy);
  // R5
  smp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> (smp_q < nsamp_q));
endmodule

// File: rtl/burst_acc.sv
`timescale 1ns/1ps
module burst_acc #(
  parameter int RES_W = 10,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [RES_W-1:0] res,
  output logic [ACC_W-1:0] acc
);
  localparam int PAD_W = ACC_W - RES_W;

  logic [ACC_W-1:0] res_ext;
  logic [ACC_W-1:0] acc_q;

  assign res_ext = {{PAD_W{1'b0}}, res};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (add) acc_q <= acc_q + res_ext;
  end

  assign acc = acc_q;

  // R6
  acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
  // R6
  acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |=> (acc_q == $past(acc_q) + $past(res_ext)));
endmodule

// File: rtl/adc_burst_seq.sv
`timescale 1ns/1ps
module adc_burst_seq
  import adc_burst_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int ACC_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_sel,
  input  logic             sw_start,
  input  logic             tmr0_ovf,
  input  logic             tmr2_ovf,
  input  logic             tmr3_ovf,
  input  logic             ext_cnv_pin,
  input  logic [2:0]       rpt_sel,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic [CNT_W-1:0] track_cnt,
  input  logic             cnv_done,
  input  logic [RES_W-1:0] cnv_result,
  output logic             cnv_en,
  output logic             cnv_start,
  output logic             busy,
  output logic [ACC_W-1:0] acc_out,
  output logic             burst_done
);
  logic trig, acc_clr, acc_add;

  burst_trig_sel #(.SYNC_STAGES(2)) u_trig (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_start(sw_start),
    .tmr0_ovf(tmr0_ovf), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
    .ext_pin(ext_cnv_pin), .trig(trig)
  );

  burst_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rpt_sel(rpt_sel),
    .settle_cnt(settle_cnt), .track_cnt(track_cnt), .cnv_done(cnv_done),
    .cnv_en(cnv_en), .cnv_start(cnv_start), .busy(busy),
    .burst_done(burst_done), .acc_clr(acc_clr), .acc_add(acc_add)
  );

  burst_acc #(.RES_W(RES_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
    .res(cnv_result), .acc(acc_out)
  );

  // R6: 32 full-scale results must fit in the sum
  initial begin
    acc_width_chk: assert (ACC_W >= RES_W + 5);
  end
endmodule

// File: tb/tb_adc_burst_seq.sv
`timescale 1ns/1ps
module tb_adc_burst_seq;
  localparam int RES_W = 10;
  localparam int ACC_W = 16;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       src_sel;
  logic             sw_start, tmr0_ovf, tmr2_ovf, tmr3_ovf, ext_cnv_pin;
  logic [2:0]       rpt_sel;
  logic [CNT_W-1:0] settle_cnt, track_cnt;
  logic             cnv_done;
  logic [RES_W-1:0] cnv_result;
  logic             cnv_en, cnv_start, busy, burst_done;
  logic [ACC_W-1:0] acc_out;

  int checks = 0;
  int errors = 0;
  int gidx   = 0;
  int lat    = 0;
  bit force_max = 1'b0;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  adc_burst_seq #(.RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_start(sw_start),
    .tmr0_ovf(tmr0_ovf), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
    .ext_cnv_pin(ext_cnv_pin), .rpt_sel(rpt_sel), .settle_cnt(settle_cnt),
    .track_cnt(track_cnt), .cnv_done(cnv_done), .cnv_result(cnv_result),
    .cnv_en(cnv_en), .cnv_start(cnv_start), .busy(busy),
    .acc_out(acc_out), .burst_done(burst_done)
  );

  function automatic int sample_val(input int i);
    if (force_max) return 1023;
    return (i * 97 + 13) & 1023;
  endfunction

  // converter model: result strobe 3 cycles after a start pulse
  always @(negedge clk) begin
    cnv_done = 1'b0;
    if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) begin
        cnv_done   = 1'b1;
        cnv_result = RES_W'(sample_val(gidx));
        gidx       = gidx + 1;
      end
    end else if (cnv_start) begin
      lat = 3;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_trig(input int src, input bit v);
    case (src)
      0: sw_start = v;
      1: tmr0_ovf = v;
      2: tmr2_ovf = v;
      3: tmr3_ovf = v;
      4: ext_cnv_pin = v;
      default: ;
    endcase
  endtask

  task automatic quiet(input string req, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk(seen == 0, req, "no burst in quiet window", seen, 0);
  endtask

  // runs one burst; caller is at a negedge
  task automatic run_burst(input string tag, input int src, input int rpt,
                           input int exp_n, input bit inject,
                           output int first_start, output int first_busy);
    int n = 0;
    int g0, exp_sum;
    first_start = -1;
    first_busy  = -1;
    src_sel = 3'(src);
    rpt_sel = 3'(rpt);
    g0 = gidx;
    drive_trig(src, 1'b1);
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (src != 4) drive_trig(src, 1'b0);
      sw_start = 1'b0; tmr0_ovf = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
      if (inject && n == 8) begin
        sw_start = 1'b1; tmr0_ovf = 1'b1; tmr2_ovf = 1'b1; tmr3_ovf = 1'b1;
      end
      if (busy && first_busy < 0) first_busy = n;
      if (cnv_start && first_start < 0) first_start = n;
      if (burst_done || n > 4000) break;
    end
    sw_start = 1'b0; tmr0_ovf = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
    exp_sum = 0;
    for (int i = g0; i < g0 + exp_n; i++) exp_sum += sample_val(i);
    chk(burst_done == 1'b1, "R9", {tag, " burst completes"}, int'(burst_done), 1);
    chk(gidx - g0 == exp_n, "R5", {tag, " conversion count"}, gidx - g0, exp_n);
    chk(int'(acc_out) == exp_sum, "R6", {tag, " sum at done"}, int'(acc_out), exp_sum);
    chk(cnv_en && busy, "R8", {tag, " enable and busy high at done"},
        int'({cnv_en, busy}), 3);
    @(negedge clk);
    chk(!cnv_en && !busy && !burst_done, "R8", {tag, " off after done"},
        int'({cnv_en, busy, burst_done}), 0);
  endtask

  task automatic t_reset;
    chk(!busy && !cnv_en && !cnv_start && !burst_done, "R1", "reset outputs",
        int'({busy, cnv_en, cnv_start, burst_done}), 0);
    chk(acc_out == '0, "R1", "reset sum", int'(acc_out), 0);
  endtask

  task automatic t_passthru;
    int fs, fb;
    int g0 = gidx;
    settle_cnt = 8'd2; track_cnt = 8'd1;
    run_burst("passthru", 0, 0, 1, 1'b0, fs, fb);
    chk(int'(acc_out) == sample_val(g0), "R7", "single sample passes through",
        int'(acc_out), sample_val(g0));
  endtask

  task automatic t_repeats;
    int fs, fb;
    settle_cnt = 8'd1; track_cnt = 8'd2;
    run_burst("rpt4", 0, 1, 4, 1'b0, fs, fb);
    run_burst("rpt8", 1, 2, 8, 1'b0, fs, fb);
    run_burst("rpt16", 2, 3, 16, 1'b0, fs, fb);
    run_burst("rpt32", 3, 4, 32, 1'b0, fs, fb);
    run_burst("rpt_code7", 0, 7, 1, 1'b0, fs, fb);
    run_burst("rpt_code5", 0, 5, 1, 1'b0, fs, fb);
  endtask

  task automatic t_full_scale;
    int fs, fb;
    force_max = 1'b1;
    settle_cnt = 8'd0; track_cnt = 8'd0;
    run_burst("full_scale", 0, 4, 32, 1'b0, fs, fb);
    chk(int'(acc_out) == 32736, "R6", "32 full-scale results", int'(acc_out), 32736);
    force_max = 1'b0;
    // next burst must start from a cleared sum
    run_burst("after_full", 0, 0, 1, 1'b0, fs, fb);
  endtask

  task automatic t_timing;
    int fs, fb;
    settle_cnt = 8'd5; track_cnt = 8'd3;
    run_burst("timing_5_3", 0, 0, 1, 1'b0, fs, fb);
    chk(fs == 10, "R4", "first start edge, settle 5 track 3", fs, 10);
    chk(fb == 1, "R9", "busy after accepting edge", fb, 1);
    settle_cnt = 8'd0; track_cnt = 8'd0;
    run_burst("timing_0_0", 0, 1, 4, 1'b0, fs, fb);
    chk(fs == 2, "R4", "first start edge, zero waits", fs, 2);
  endtask

  task automatic t_ignore_busy;
    int fs, fb;
    settle_cnt = 8'd3; track_cnt = 8'd2;
    run_burst("busy_ignore", 0, 2, 8, 1'b1, fs, fb);
    quiet("R9", 20);
  endtask

  task automatic t_sources;
    int fs, fb;
    settle_cnt = 8'd1; track_cnt = 8'd1;
    for (int s = 1; s <= 3; s++) begin
      src_sel = 3'(s);
      for (int o = 0; o <= 3; o++) if (o != s) drive_trig(o, 1'b1);
      @(negedge clk);
      for (int o = 0; o <= 3; o++) drive_trig(o, 1'b0);
      quiet("R2", 6);
      run_burst("selected_src", s, 1, 4, 1'b0, fs, fb);
    end
    src_sel = 3'd6;
    for (int o = 0; o <= 4; o++) drive_trig(o, 1'b1);
    @(negedge clk);
    for (int o = 0; o <= 4; o++) drive_trig(o, 1'b0);
    quiet("R2", 8);
  endtask

  task automatic t_pin;
    int fs, fb;
    settle_cnt = 8'd2; track_cnt = 8'd1;
    run_burst("pin", 4, 1, 4, 1'b0, fs, fb);
    chk(fb == 3, "R3", "pin sync latency to busy", fb, 3);
    chk(fs == 7, "R3", "pin first start edge", fs, 7);
    quiet("R3", 20);
    ext_cnv_pin = 1'b0;
    quiet("R3", 4);
  endtask

  initial begin
    rst_n = 1'b0;
    src_sel = 3'd0; rpt_sel = 3'd0;
    sw_start = 1'b0; tmr0_ovf = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
    ext_cnv_pin = 1'b0;
    settle_cnt = '0; track_cnt = '0;
    cnv_result = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_repeats();
    t_full_scale();
    t_timing();
    t_ignore_busy();
    t_sources();
    t_pin();
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule